// File: doc/BRIEF.md
# Two-Hot Opcode Decoder

This block decodes an 8-bit opcode field in which each operation is named by exactly two set bits. Eight positions give 28 pairs, so 28 operations. Telling legal fields from the rest is a population-count test, and each operation output is a two-input AND. No programmable logic array is needed. Because the logic is this small, a copy can sit in every pipe stage.

Each field comes with a valid strobe. One cycle later the block presents a registered result. A legal field gives a one-hot operation vector and a 5-bit operation index. A field with zero or one bit set is reported as a NOP. A field with three or more bits set raises an illegal flag. The block does not pick the field out of the instruction word, does not handle operands and does not take traps.

Top module: `two_hot_op_decoder`

## Requirements
- R1: For a valid field with exactly two bits set, at positions i<j, the next cycle shows op_onehot_o with only bit k set, where k = i*(15-i)/2 + (j-i-1). This is lexicographic pair order: (0,1)=0, (0,2)=1, (1,2)=7, (6,7)=27.
- R2: For such a legal field, op_idx_o equals k in the same cycle that op_onehot_o is presented.
- R3: A valid field with fewer than two bits set gives is_nop_o=1, is_illegal_o=0, op_onehot_o=0 and op_idx_o=0 one cycle later.
- R4: A valid field with more than two bits set gives is_illegal_o=1, is_nop_o=0, op_onehot_o=0 and op_idx_o=0 one cycle later.
- R5: Whenever out_valid_o is 1, exactly one of three classes is active: legal (op_onehot_o nonzero), NOP, or illegal.
- R6: out_valid_o equals the value in_valid_i had at the previous rising clock edge.
- R7: A cycle with in_valid_i=0 is ignored whatever the field holds. On the next cycle op_onehot_o, op_idx_o, is_nop_o and is_illegal_o are all 0.
- R8: While rst_ni is low, every output is 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Field strobe |
| field_i | input | 8 | Opcode field |
| out_valid_o | output | 1 | Registered strobe |
| op_onehot_o | output | 28 | One-hot operation vector |
| op_idx_o | output | 5 | Operation index |
| is_nop_o | output | 1 | Field had fewer than two bits set |
| is_illegal_o | output | 1 | Field had more than two bits set |

## Verification
Every result is due exactly one rising edge after the field and strobe are applied, because a single register stage sits between input and output. The bench drives each stimulus just after a falling edge. It checks the matching result at the following falling edge, so exactly one rising edge lies between drive and sample. Fields stream back to back, so every check also shows that the previous field has been replaced. All 256 field values are swept and the expected class and pair index are computed arithmetically. Idle cycles that carry a legal field check that the outputs clear. Reset is checked while the inputs are active.

// File: rtl/two_hot_dec_pkg.sv
package two_hot_dec_pkg;
  typedef enum logic [1:0] {CLS_NOP = 2'd0, CLS_OP = 2'd1, CLS_BAD = 2'd2} op_cls_e;

  function automatic int num_pairs(input int w);
    return w * (w - 1) / 2;
  endfunction

  // lexicographic index of pair (i,j), i<j
  function automatic int pair_index(input int i, input int j, input int w);
    return i * (2 * w - i - 1) / 2 + (j - i - 1);
  endfunction
endpackage

// File: rtl/two_hot_weight_cls.sv
module two_hot_weight_cls
  import two_hot_dec_pkg::*;
#(
  parameter int FIELD_W = 8,
  localparam int CNT_W = $clog2(FIELD_W + 1)
) (
  input  logic [FIELD_W-1:0] field_i,
  output op_cls_e            cls_o
);
  logic [CNT_W-1:0] weight;

  always_comb begin
    weight = '0;
    for (int b = 0; b < FIELD_W; b++) weight = weight + CNT_W'(field_i[b]);
  end

  always_comb begin
    if (weight < CNT_W'(2))       cls_o = CLS_NOP;
    else if (weight == CNT_W'(2)) cls_o = CLS_OP;
    else                          cls_o = CLS_BAD;
  end
endmodule

// File: rtl/two_hot_pair_matrix.sv
module two_hot_pair_matrix
  import two_hot_dec_pkg::*;
#(
  parameter int FIELD_W = 8,
  localparam int NUM_OPS = FIELD_W * (FIELD_W - 1) / 2
) (
  input  logic [FIELD_W-1:0] field_i,
  input  logic               legal_i,
  output logic [NUM_OPS-1:0] hot_o
);
  for (genvar i = 0; i < FIELD_W - 1; i++) begin : g_lo
    for (genvar j = i + 1; j < FIELD_W; j++) begin : g_hi
      localparam int K = pair_index(i, j, FIELD_W);
      assign hot_o[K] = legal_i & field_i[i] & field_i[j];
    end
  end
endmodule

// File: rtl/two_hot_idx_enc.sv
module two_hot_idx_enc #(
  parameter int NUM_OPS = 28,
  localparam int IDX_W = $clog2(NUM_OPS)
) (
  input  logic [NUM_OPS-1:0] hot_i,
  output logic [IDX_W-1:0]   idx_o
);
  // OR-encode; input is one-hot or zero
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < NUM_OPS; k++)
      if (hot_i[k]) idx_o = idx_o | IDX_W'(k);
  end
endmodule

// File: rtl/two_hot_op_decoder.sv
module two_hot_op_decoder
  import two_hot_dec_pkg::*;
#(
  parameter int FIELD_W = 8,
  localparam int NUM_OPS = FIELD_W * (FIELD_W - 1) / 2,
  localparam int IDX_W = $clog2(NUM_OPS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic               out_valid_o,
  output logic [NUM_OPS-1:0] op_onehot_o,
  output logic [IDX_W-1:0]   op_idx_o,
  output logic               is_nop_o,
  output logic               is_illegal_o
);
  op_cls_e            cls;
  logic [NUM_OPS-1:0] hot;
  logic [IDX_W-1:0]   idx;

  two_hot_weight_cls #(.FIELD_W(FIELD_W)) u_cls (
    .field_i(field_i),
    .cls_o  (cls)
  );

  two_hot_pair_matrix #(.FIELD_W(FIELD_W)) u_matrix (
    .field_i(field_i),
    .legal_i(cls == CLS_OP),
    .hot_o  (hot)
  );

  two_hot_idx_enc #(.NUM_OPS(NUM_OPS)) u_enc (
    .hot_i(hot),
    .idx_o(idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      op_onehot_o  <= '0;
      op_idx_o     <= '0;
      is_nop_o     <= 1'b0;
      is_illegal_o <= 1'b0;
    end else begin
      out_valid_o  <= in_valid_i;
      op_onehot_o  <= in_valid_i ? hot : '0;
      op_idx_o     <= in_valid_i ? idx : '0;
      is_nop_o     <= in_valid_i && (cls == CLS_NOP);
      is_illegal_o <= in_valid_i && (cls == CLS_BAD);
    end
  end
endmodule

// File: rtl/two_hot_op_decoder_chk.sv
module two_hot_op_decoder_chk #(
  parameter int FIELD_W = 8,
  localparam int NUM_OPS = FIELD_W * (FIELD_W - 1) / 2,
  localparam int IDX_W = $clog2(NUM_OPS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic [FIELD_W-1:0] field_i,
  input logic               out_valid_o,
  input logic [NUM_OPS-1:0] op_onehot_o,
  input logic [IDX_W-1:0]   op_idx_o,
  input logic               is_nop_o,
  input logic               is_illegal_o
);
  AST_ONEHOT_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(op_onehot_o)); // R1
  AST_IDX_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|op_onehot_o) |-> op_onehot_o[op_idx_o]); // R2
  AST_NOP_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && $countones(field_i) < 2) |=> (is_nop_o && op_onehot_o == '0 && op_idx_o == '0)); // R3
  AST_BAD_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && $countones(field_i) > 2) |=> (is_illegal_o && op_onehot_o == '0 && op_idx_o == '0)); // R4
  AST_ONE_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $countones({|op_onehot_o, is_nop_o, is_illegal_o}) == 1); // R5
  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R6
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (op_onehot_o == '0 && op_idx_o == '0 && !is_nop_o && !is_illegal_o)); // R7
  always_comb if (!rst_ni) AST_RESET_CLEAR: assert final (!out_valid_o && op_onehot_o == '0
    && op_idx_o == '0 && !is_nop_o && !is_illegal_o); // R8
endmodule

bind two_hot_op_decoder two_hot_op_decoder_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .field_i(field_i),
  .out_valid_o(out_valid_o), .op_onehot_o(op_onehot_o), .op_idx_o(op_idx_o),
  .is_nop_o(is_nop_o), .is_illegal_o(is_illegal_o)
);

// File: tb/two_hot_op_decoder_tb.sv
module two_hot_op_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NOPS = 28;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic [W-1:0]    field_i = '0;
  logic            out_valid_o;
  logic [NOPS-1:0] op_onehot_o;
  logic [4:0]      op_idx_o;
  logic            is_nop_o;
  logic            is_illegal_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  two_hot_op_decoder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .field_i(field_i),
    .out_valid_o(out_valid_o), .op_onehot_o(op_onehot_o), .op_idx_o(op_idx_o),
    .is_nop_o(is_nop_o), .is_illegal_o(is_illegal_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle, check at the following falling edge
  task automatic apply(input logic vld, input logic [W-1:0] f);
    int cnt, lo, hi, k;
    logic [NOPS-1:0] e_hot;
    logic [4:0] e_idx;
    in_valid_i = vld;
    field_i = f;
    cnt = 0; lo = -1; hi = -1;
    for (int b = 0; b < W; b++) if (f[b]) begin
      cnt++;
      if (lo < 0) lo = b; else if (hi < 0) hi = b;
    end
    e_hot = '0; e_idx = '0;
    if (vld && cnt == 2) begin
      k = lo * (2*W - lo - 1) / 2 + (hi - lo - 1);
      e_hot[k] = 1'b1;
      e_idx = 5'(k);
    end
    @(negedge clk_i);
    chk("R6 valid", 64'(out_valid_o), 64'(vld));
    if (!vld) begin
      chk("R7 idle", 64'({op_onehot_o, op_idx_o, is_nop_o, is_illegal_o}), 64'(0));
    end else if (cnt == 2) begin
      chk("R1 onehot", 64'(op_onehot_o), 64'(e_hot));
      chk("R2 idx", 64'(op_idx_o), 64'(e_idx));
      chk("R5 class", 64'({is_nop_o, is_illegal_o}), 64'(0));
    end else if (cnt < 2) begin
      chk("R3 nop", 64'({op_onehot_o, op_idx_o, is_nop_o, is_illegal_o}), 64'(2));
    end else begin
      chk("R4 illegal", 64'({op_onehot_o, op_idx_o, is_nop_o, is_illegal_o}), 64'(1));
    end
  endtask

  initial begin
    in_valid_i = 1'b1;
    field_i = 8'h03;
    repeat (2) @(negedge clk_i);
    chk("R8 reset", 64'({out_valid_o, op_onehot_o, op_idx_o, is_nop_o, is_illegal_o}), 64'(0));
    rst_ni = 1'b1;
    for (int v = 0; v < 256; v++) apply(1'b1, 8'(v));
    // known corners
    apply(1'b1, 8'h03); chk("R2 pair01", 64'(op_idx_o), 64'(0));
    apply(1'b1, 8'h06); chk("R2 pair12", 64'(op_idx_o), 64'(7));
    apply(1'b1, 8'hC0); chk("R2 pair67", 64'(op_idx_o), 64'(27));
    apply(1'b0, 8'h81);
    apply(1'b0, 8'hFF);
    apply(1'b1, 8'h00);
    apply(1'b0, 8'h00);
    apply(1'b1, 8'hFF);
    apply(1'b1, 8'h81);
    for (int v = 0; v < 256; v += 7) apply(v[0], 8'(v * 37));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule